// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Parking

This block decides which of several symmetric agents owns a shared request bus. Each agent drives one request line. The block registers the requests, picks a winner by round-robin priority, and drives a one-hot grant. It also reports the winner's ID, the rotating priority pointer and whether the bus currently has a symmetric owner.

The pointer always names the agent that ranks lowest in the next contest. Once an agent owns the bus, it keeps the grant while it has nothing to do (parking). A later request from the same agent therefore needs no arbitration. When another agent asks and the owner has no request of its own, the owner is released through a two-cycle handshake, and only after that does the new grant appear.

An idle bus is granted two clocks after a request rises. A handoff from a busy owner takes four clocks. Two synchronous fault inputs, an address-error reset and a bus-init reset, send the block back to idle without disturbing the pointer.

Top module: `rpa_top`

## Requirements
- R1: After the synchronous active-low reset, `agent_gnt` is all zero, `own_busy` is 0, `owner_id` is 0 and `rot_id` equals N_AGENTS-1 (3 by default).
- R2: From idle, a request driven before clock edge k produces no grant after edge k and the grant to the winner after edge k+1.
- R3: The winner of a contest is the first requesting agent in the order rot_id+1, rot_id+2, … wrapping modulo N_AGENTS, with rot_id itself checked last. Agent i's request is bit i of `agent_req` and its grant is bit i of `agent_gnt`.
- R4: On every new grant, `rot_id` takes the ID of the new owner. While the bus is busy, `rot_id` equals the current or departing owner's ID.
- R5: The owner keeps its grant while no registered request is present, and also while its own registered request is set, whatever the other agents request.
- R6: When the owner's registered request is clear and another agent's registered request is set, the grant drops after the next edge, stays all zero for two cycles with `own_busy` held at 1, and the new owner's grant appears four edges after the other agent's request was driven.
- R7: The target of a handoff is fixed when the handoff starts, and the handoff completes to that agent even if the requests change during the two handshake cycles.
- R8: A 1 on `addr_err_rst` or `bus_init_rst` at an edge leaves `agent_gnt` all zero and `own_busy` at 0 after that edge, and `rot_id` unchanged.
- R9: At most one bit of `agent_gnt` is set at any time. `owner_id` is the index of the set bit, or 0 when none is set.
- R10: `own_busy` goes to 1 with the first grant after idle and returns to 0 only through R1 or R8. While it is 0, no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_err_rst | input | 1 | Address-error reset, returns the block to idle |
| bus_init_rst | input | 1 | Bus-init reset, returns the block to idle |
| agent_req | input | N_AGENTS | Request line of each agent |
| agent_gnt | output | N_AGENTS | One-hot ownership grant |
| owner_id | output | $clog2(N_AGENTS) | Index of the granted agent, 0 if none |
| rot_id | output | $clog2(N_AGENTS) | Agent with lowest priority in the next contest |
| own_busy | output | 1 | 1 while a symmetric owner exists or a handoff is in flight |

## Verification
The bench targets the wrap-around of the rotation. A picker that scans from zero, or that starts the scan at the pointer rather than one past it, would hand agent 0 the bus where agent 3 should win. It also changes requests in the middle of a handshake. A design that re-arbitrates at the end of the handoff would grant whichever agent asked last, not the one chosen at release. Parking is tested with all requests withdrawn and with the owner re-asserting while others wait; a design that rearbitrates there would drop the grant for no reason. Fault resets are applied mid-ownership and mid-handoff, where a wrong design would either leave a grant standing or move the pointer.

// File: rtl/rpa_pkg.sv
// Shared types for the rotating-priority parking arbiter.
// Assumes nothing beyond being compiled before the modules that import it.
package rpa_pkg;

    // Controller phases: no owner, parked/active owner, two handshake cycles.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN  = 2'd1,
        ST_HS1  = 2'd2,
        ST_HS2  = 2'd3
    } rpa_state_t;

endpackage

// File: rtl/rpa_req_stage.sv
// Request capture stage: registers the raw agent request lines once.
// Every arbitration decision is taken from this registered copy, so the
// controller sees stable requests for a whole cycle.
// Assumes requests are synchronous to clk. Reset is synchronous, active low.
module rpa_req_stage #(
    parameter int N_AGENTS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] req_in,
    output logic [N_AGENTS-1:0] req_q
);

    // Capture each request bit; one flop per agent.
    for (genvar g = 0; g < N_AGENTS; g++) begin : g_req_flop
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
            end else begin
                req_q[g] <= req_in[g];
            end
        end
    end

endmodule

// File: rtl/rpa_rr_pick.sv
// Round-robin picker (combinational). It scans the agents starting one past
// `lowest` and wrapping around, so `lowest` itself is tried last.
// Assumes N_AGENTS >= 2. Output `win` is only meaningful when `any` is 1.
module rpa_rr_pick #(
    parameter int N_AGENTS = 4,
    localparam int IDW     = $clog2(N_AGENTS)
) (
    input  logic [N_AGENTS-1:0] req_vec,
    input  logic [IDW-1:0]      lowest,
    output logic                any,
    output logic [IDW-1:0]      win
);

    // Rotating scan: the first requester after `lowest` wins.
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 1; k <= N_AGENTS; k++) begin
            int idx;
            idx = (int'(lowest) + k) % N_AGENTS;
            if (!any && req_vec[idx]) begin
                any = 1'b1;
                win = IDW'(idx);
            end
        end
    end

endmodule

// File: rtl/rpa_ctrl.sv
// Ownership controller. It holds the idle/busy state, the rotating pointer,
// the grant register and the handoff target.
// Idle: any registered request wins the bus in one step.
// Own:  the owner is parked until another agent asks while the owner does not.
// Hs1/Hs2: the two handshake cycles with the grant removed. The target is
// latched when the handoff starts.
// Either fault reset forces idle and keeps the pointer.
// Assumes req_q comes from the capture stage. Reset is synchronous, active low.
module rpa_ctrl
    import rpa_pkg::*;
#(
    parameter int N_AGENTS = 4,
    localparam int IDW     = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [N_AGENTS-1:0] req_q,
    output logic [N_AGENTS-1:0] gnt,
    output logic [IDW-1:0]      rot,
    output logic                busy
);

    localparam logic [IDW-1:0] ROT_RESET = IDW'(N_AGENTS - 1);

    rpa_state_t          state;
    logic [IDW-1:0]      hand_tgt;
    logic [N_AGENTS-1:0] own_mask;
    logic [N_AGENTS-1:0] other_req;
    logic                any_all;
    logic [IDW-1:0]      win_all;
    logic                any_oth;
    logic [IDW-1:0]      win_oth;
    logic [N_AGENTS-1:0] dec_all;
    logic [N_AGENTS-1:0] dec_tgt;

    // Decode the pointer and the two candidate IDs to one-hot vectors.
    for (genvar g = 0; g < N_AGENTS; g++) begin : g_dec
        assign own_mask[g] = (rot == IDW'(g));
        assign dec_all[g]  = (win_all == IDW'(g));
        assign dec_tgt[g]  = (hand_tgt == IDW'(g));
    end

    // Requests from agents other than the current owner.
    assign other_req = req_q & ~own_mask;

    // Picker over all requests, used when arbitrating from idle.
    rpa_rr_pick #(.N_AGENTS(N_AGENTS)) u_pick_all (
        .req_vec (req_q),
        .lowest  (rot),
        .any     (any_all),
        .win     (win_all)
    );

    // Picker over non-owner requests, used to choose a handoff target.
    rpa_rr_pick #(.N_AGENTS(N_AGENTS)) u_pick_oth (
        .req_vec (other_req),
        .lowest  (rot),
        .any     (any_oth),
        .win     (win_oth)
    );

    // Ownership state machine with pointer and grant updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            gnt      <= '0;
            rot      <= ROT_RESET;
            hand_tgt <= '0;
        end else if (flush) begin
            state <= ST_IDLE;
            gnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (any_all) begin
                        gnt   <= dec_all;
                        rot   <= win_all;
                        state <= ST_OWN;
                    end
                end
                ST_OWN: begin
                    if (!req_q[rot] && any_oth) begin
                        gnt      <= '0;
                        hand_tgt <= win_oth;
                        state    <= ST_HS1;
                    end
                end
                ST_HS1: begin
                    state <= ST_HS2;
                end
                ST_HS2: begin
                    gnt   <= dec_tgt;
                    rot   <= hand_tgt;
                    state <= ST_OWN;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Busy covers ownership and the handshake cycles.
    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/rpa_top.sv
// Rotating-priority arbiter with bus parking for N_AGENTS symmetric agents.
// It chains the request capture stage, the ownership controller and an
// owner ID encoder. Agent i has the fixed ID i.
// Assumes all inputs are synchronous to clk. Reset is synchronous, active low.
module rpa_top #(
    parameter int N_AGENTS = 4,
    localparam int IDW     = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_err_rst,
    input  logic                bus_init_rst,
    input  logic [N_AGENTS-1:0] agent_req,
    output logic [N_AGENTS-1:0] agent_gnt,
    output logic [IDW-1:0]      owner_id,
    output logic [IDW-1:0]      rot_id,
    output logic                own_busy
);

    logic [N_AGENTS-1:0] req_q;
    logic                flush;

    // Either fault reset returns the block to idle.
    assign flush = addr_err_rst | bus_init_rst;

    // Register the raw requests.
    rpa_req_stage #(.N_AGENTS(N_AGENTS)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (agent_req),
        .req_q  (req_q)
    );

    // Arbitration and ownership tracking.
    rpa_ctrl #(.N_AGENTS(N_AGENTS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .req_q (req_q),
        .gnt   (agent_gnt),
        .rot   (rot_id),
        .busy  (own_busy)
    );

    // Encode the one-hot grant into the owner index (0 when no grant).
    always_comb begin
        owner_id = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (agent_gnt[i]) begin
                owner_id = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/rpa_sva.sv
// Assertion checker for rpa_top, attached with the bind below.
// Assumes it watches the registered requests of the top through req_q.
module rpa_sva #(
    parameter int N_AGENTS = 4,
    localparam int IDW     = $clog2(N_AGENTS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                addr_err_rst,
    input logic                bus_init_rst,
    input logic [N_AGENTS-1:0] agent_gnt,
    input logic [IDW-1:0]      owner_id,
    input logic [IDW-1:0]      rot_id,
    input logic                own_busy,
    input logic [N_AGENTS-1:0] req_q
);

    logic flt;
    assign flt = addr_err_rst | bus_init_rst;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(agent_gnt)); // R9
    AST_OWNER_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        (|agent_gnt) |-> agent_gnt[owner_id]); // R9
    AST_ROT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (own_busy && |agent_gnt) |-> agent_gnt[rot_id]); // R4
    AST_FAULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> (!own_busy && agent_gnt == '0)); // R8
    AST_FAULT_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> $stable(rot_id)); // R8
    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((|agent_gnt) && req_q == '0 && !flt) |=> $stable(agent_gnt)); // R5
    AST_PARK_OWNREQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(agent_gnt & req_q)) && !flt) |=> $stable(agent_gnt)); // R5
    AST_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(|agent_gnt) && own_busy && !flt) |=> (agent_gnt == '0 && own_busy)); // R6
    AST_IDLE_NOGNT: assert property (@(posedge clk) disable iff (!rst_n)
        !own_busy |-> agent_gnt == '0); // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (own_busy && !flt) |=> own_busy); // R10

endmodule

bind rpa_top rpa_sva #(.N_AGENTS(N_AGENTS)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_err_rst (addr_err_rst),
    .bus_init_rst (bus_init_rst),
    .agent_gnt    (agent_gnt),
    .owner_id     (owner_id),
    .rot_id       (rot_id),
    .own_busy     (own_busy),
    .req_q        (req_q)
);

// File: tb/rpa_top_test.sv
// Bench for rpa_top: directed corner cases followed by seeded random
// traffic. Every cycle is compared against a cycle-level model built from
// the requirements.
module rpa_top_test;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_err_rst = 1'b0;
    logic       bus_init_rst = 1'b0;
    logic [3:0] agent_req = '0;
    logic [3:0] agent_gnt;
    logic [1:0] owner_id;
    logic [1:0] rot_id;
    logic       own_busy;

    int n_chk = 0;
    int n_bad = 0;

    // Model state: registered requests, phase, grant, pointer, target.
    logic [3:0] m_rq;
    int         m_st;
    logic [3:0] m_g;
    int         m_rot;
    int         m_tgt;

    rpa_top #(.N_AGENTS(N)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_err_rst (addr_err_rst),
        .bus_init_rst (bus_init_rst),
        .agent_req    (agent_req),
        .agent_gnt    (agent_gnt),
        .owner_id     (owner_id),
        .rot_id       (rot_id),
        .own_busy     (own_busy)
    );

    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a miscompare.
    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic int pick(input logic [3:0] r, input int low);
        for (int k = 1; k <= N; k++) begin
            if (r[(low + k) % N]) return (low + k) % N;
        end
        return -1;
    endfunction

    function automatic int enc(input logic [3:0] g);
        for (int i = 0; i < N; i++) if (g[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge, using the values seen before the edge.
    task automatic m_step(input logic [3:0] r, input logic f, input logic rs);
        if (!rs) begin
            m_st = 0; m_g = '0; m_rot = N - 1; m_tgt = 0;
        end else if (f) begin
            m_st = 0; m_g = '0;
        end else begin
            case (m_st)
                0: if (m_rq != 0) begin
                       m_rot = pick(m_rq, m_rot); m_g = 4'b1 << m_rot; m_st = 1;
                   end
                1: if (!m_rq[m_rot] && (m_rq & ~(4'b1 << m_rot)) != 0) begin
                       m_tgt = pick(m_rq & ~(4'b1 << m_rot), m_rot); m_g = '0; m_st = 2;
                   end
                2: m_st = 3;
                default: begin m_g = 4'b1 << m_tgt; m_rot = m_tgt; m_st = 1; end
            endcase
        end
        m_rq = rs ? r : 4'b0;
    endtask

    // Apply inputs at the falling edge, step one clock, compare at the next fall.
    task automatic tick(input logic [3:0] r, input logic ae, input logic bi, input logic rs);
        agent_req = r; addr_err_rst = ae; bus_init_rst = bi; rst_n = rs;
        @(posedge clk);
        m_step(r, ae | bi, rs);
        @(negedge clk);
        chk("R3 grant vs model", int'(agent_gnt), int'(m_g));
        chk("R4 rot_id vs model", int'(rot_id), m_rot);
        chk("R10 busy vs model", int'(own_busy), int'(m_st != 0));
        chk("R9 owner_id vs model", int'(owner_id), enc(m_g));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        m_rq = '0; m_st = 0; m_g = '0; m_rot = N - 1; m_tgt = 0;
        @(negedge clk);
        tick(4'b0000, 1'b0, 1'b0, 1'b0);
        tick(4'b0000, 1'b0, 1'b0, 1'b0);
        // R1 reset state
        chk("R1 grant", int'(agent_gnt), 0);
        chk("R1 busy", int'(own_busy), 0);
        chk("R1 rot_id", int'(rot_id), 3);
        chk("R1 owner_id", int'(owner_id), 0);

        // R2 idle latency: agent 1 requests
        tick(4'b0010, 1'b0, 1'b0, 1'b1);
        chk("R2 no grant after one edge", int'(agent_gnt), 0);
        tick(4'b0010, 1'b0, 1'b0, 1'b1);
        chk("R2 grant after two edges", int'(agent_gnt), 2);
        chk("R4 rot_id takes owner", int'(rot_id), 1);
        chk("R9 owner_id", int'(owner_id), 1);

        // R5 parking with no requests
        for (int i = 0; i < 5; i++) tick(4'b0000, 1'b0, 1'b0, 1'b1);
        chk("R5 parked grant", int'(agent_gnt), 2);

        // R6/R3 handoff: agents 0 and 2 ask, owner 1 silent; 2 is next after 1
        tick(4'b0101, 1'b0, 1'b0, 1'b1);
        chk("R6 grant held edge1", int'(agent_gnt), 2);
        tick(4'b0101, 1'b0, 1'b0, 1'b1);
        chk("R6 grant dropped edge2", int'(agent_gnt), 0);
        chk("R6 busy in handshake", int'(own_busy), 1);
        tick(4'b0101, 1'b0, 1'b0, 1'b1);
        chk("R6 grant zero edge3", int'(agent_gnt), 0);
        chk("R4 rot_id holds departing owner", int'(rot_id), 1);
        tick(4'b0101, 1'b0, 1'b0, 1'b1);
        chk("R6 R3 new grant edge4", int'(agent_gnt), 4);
        chk("R4 rot_id new owner", int'(rot_id), 2);

        // R5 owner 2 keeps asking while 0 waits
        for (int i = 0; i < 4; i++) tick(4'b0101, 1'b0, 1'b0, 1'b1);
        chk("R5 owner request keeps grant", int'(agent_gnt), 4);

        // R7 target latched: agent 0 asks, then only agent 3 during handshake
        tick(4'b0001, 1'b0, 1'b0, 1'b1);
        tick(4'b1000, 1'b0, 1'b0, 1'b1);
        chk("R7 handshake started", int'(agent_gnt), 0);
        tick(4'b1000, 1'b0, 1'b0, 1'b1);
        tick(4'b1000, 1'b0, 1'b0, 1'b1);
        chk("R7 latched target granted", int'(agent_gnt), 1);
        chk("R7 rot_id", int'(rot_id), 0);

        // R8 address-error reset during ownership
        tick(4'b0000, 1'b1, 1'b0, 1'b1);
        chk("R8 grant cleared", int'(agent_gnt), 0);
        chk("R8 idle", int'(own_busy), 0);
        chk("R8 rot_id kept", int'(rot_id), 0);
        tick(4'b0000, 1'b0, 1'b0, 1'b1);
        tick(4'b0000, 1'b0, 1'b0, 1'b1);

        // R3 wrap: pointer 0, agents 0 and 3 ask -> agent 3 wins
        tick(4'b1001, 1'b0, 1'b0, 1'b1);
        tick(4'b1001, 1'b0, 1'b0, 1'b1);
        chk("R3 wrap winner", int'(agent_gnt), 8);
        chk("R4 rot_id wrap", int'(rot_id), 3);

        // R8 bus-init reset
        tick(4'b0000, 1'b0, 1'b1, 1'b1);
        chk("R8 bus-init idle", int'(own_busy), 0);
        chk("R8 bus-init rot kept", int'(rot_id), 3);
        tick(4'b0000, 1'b0, 1'b0, 1'b1);

        // R3 pointer 3: agents 0,1,2 ask -> agent 0 wins
        tick(4'b0111, 1'b0, 1'b0, 1'b1);
        tick(4'b0111, 1'b0, 1'b0, 1'b1);
        chk("R3 after pointer 3", int'(agent_gnt), 1);

        // Random traffic with occasional faults and resets
        for (int c = 0; c < 6000; c++) begin
            logic [3:0] r;
            logic ae, bi, rs;
            r  = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) r = '0;
            ae = ($urandom_range(0, 79) == 0);
            bi = ($urandom_range(0, 79) == 0);
            rs = ($urandom_range(0, 999) != 0);
            tick(r, ae, bi, rs);
            if ($urandom_range(0, 7) == 0) begin
                for (int h = 0; h < 3; h++) tick(r, 1'b0, 1'b0, 1'b1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule